// File: doc/BRIEF.md
# Truncating Extended-Precision to Integer Converter

This block takes an 80-bit extended-precision floating-point value (sign, 15-bit biased exponent with bias 16383, 64-bit significand whose top bit is the explicit integer bit) and turns it into a signed two's-complement integer of 16, 32 or 64 bits. The conversion always chops toward zero. No rounding-mode input exists, so no control-word setting can change the result.

A pipeline front end presents the top-of-stack operand together with a width code and a one-cycle valid strobe. One clock later the block returns a 64-bit result, an invalid flag and an inexact flag, and it raises a one-cycle pop strobe that tells the register stack to discard its top entry. Results for the narrower widths arrive already sign-extended to 64 bits. When the input is a NaN, an infinity, or a value whose truncated magnitude does not fit the chosen width, the block raises the invalid flag and returns the most negative number of that width.

Top module: `xfp_trunc_cvt`

## Requirements
- R1: A finite operand of magnitude at least 1.0 whose integer part fits the selected width gives that integer part, with its sign, in two's complement. The fraction is dropped toward zero, so -2.75 gives -2 and 2.75 gives 2.
- R2: An operand whose exponent field is all ones (infinity or NaN) sets invalidOut and returns the integer-indefinite value for the selected width.
- R3: A truncated magnitude outside the selected signed range sets invalidOut and returns the most negative value of that width, sign-extended to 64 bits. -2^(W-1) and -(2^(W-1)+0.5) are in range. +2^(W-1) is out of range.
- R4: precOut is 1 when truncation discarded any nonzero significand bit. It is 0 whenever invalidOut is 1.
- R5: An operand with a biased exponent below 16383 (zeros, denormals, and magnitudes below 1.0) returns 0 with invalidOut 0. precOut is 1 exactly when the significand is nonzero.
- R6: widthSel code 0 selects 16 bits, code 1 selects 32 bits, and codes 2 and 3 select 64 bits. For the 16-bit and 32-bit widths, every bit of resOut above the width equals the sign bit of the width.
- R7: resOut, invalidOut and precOut update on the clock edge that samples inValid high. popOut is 1 in that cycle and only then.
- R8: While rstN is low, resOut, invalidOut, precOut and popOut are all 0.
- R9: resOut, invalidOut and precOut hold their values while inValid is low, whatever the operand and width inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand and width are valid this cycle |
| operand | input | 80 | Extended-precision value from top of stack |
| widthSel | input | 2 | Destination width code |
| resOut | output | 64 | Signed integer result, sign-extended |
| invalidOut | output | 1 | Invalid-operation flag |
| precOut | output | 1 | Inexact (precision) flag |
| popOut | output | 1 | One-cycle stack pop strobe |

## Verification
The bench builds the block with its default parameters: a 15-bit exponent and a 64-bit significand. With these, the full extended format is reachable, including the 2^63 edge of the 64-bit range and exponents far beyond it. Random operands have exponents clustered around the bias, from three below it to past the 64-bit limit. This drives every right-shift amount, both sides of each width's range limit, and the sub-unity region. Directed cases pin down the exact edges: ±2^(W-1), -(2^(W-1)+0.5), zero, a denormal, infinity and NaN.

// File: rtl/xfp_trunc_pkg.sv
package xfp_trunc_pkg;

  typedef enum logic [1:0] {
    WID16 = 2'd0,
    WID32 = 2'd1,
    WID64 = 2'd2
  } width_e;

  typedef enum logic [1:0] {
    CLS_FINITE  = 2'd0,
    CLS_SMALL   = 2'd1,
    CLS_HUGE    = 2'd2,
    CLS_SPECIAL = 2'd3
  } opclass_e;

  typedef struct packed {
    logic   capture;
    width_e widthCode;
  } ctrl_strobe_t;

  function automatic int widthBits(width_e w);
    case (w)
      WID16:   return 16;
      WID32:   return 32;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/xfp_trunc_ctrl.sv
module xfp_trunc_ctrl
  import xfp_trunc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   widthSel,
  output ctrl_strobe_t strb,
  output logic         popOut
);

  width_e widthDec;

  always_comb begin
    case (widthSel)
      2'd0:    widthDec = WID16;
      2'd1:    widthDec = WID32;
      default: widthDec = WID64;
    endcase
  end

  always_comb begin
    strb.capture   = inValid;
    strb.widthCode = widthDec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) popOut <= 1'b0;
    else       popOut <= inValid;
  end

endmodule

// File: rtl/xfp_trunc_dp.sv
module xfp_trunc_dp
  import xfp_trunc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobe_t               strb,
  input  logic [EXP_W+SIG_W:0]       operand,
  output logic [SIG_W-1:0]           resOut,
  output logic                       invalidOut,
  output logic                       precOut
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int SH_W = $clog2(SIG_W);
  localparam int NUM_WID = 3;

  logic             sgn;
  logic [EXP_W-1:0] expF;
  logic [SIG_W-1:0] sig;
  logic [EXP_W-1:0] unb;
  logic [EXP_W-1:0] shFull;
  logic [SH_W-1:0]  shAmt;
  logic [SIG_W-1:0] magInt;
  logic             lostBits;
  logic [SIG_W-1:0] limit;
  logic [SIG_W-1:0] indef;
  logic             overRange;
  opclass_e         opClass;

  logic [SIG_W-1:0] limitTab [NUM_WID];

  // one range limit per supported width
  for (genvar g = 0; g < NUM_WID; g++) begin : g_lim
    localparam int WB = widthBits(width_e'(g));
    assign limitTab[g] = SIG_W'(1) << (WB - 1);
  end

  assign sgn  = operand[EXP_W+SIG_W];
  assign expF = operand[EXP_W+SIG_W-1:SIG_W];
  assign sig  = operand[SIG_W-1:0];

  assign unb    = expF - EXP_W'(BIAS);
  assign shFull = EXP_W'(SIG_W - 1) - unb;
  assign shAmt  = shFull[SH_W-1:0];
  assign magInt = sig >> shAmt;
  assign lostBits = |(sig & ~({SIG_W{1'b1}} << shAmt));

  assign limit = limitTab[strb.widthCode];
  assign indef = ~(limit - SIG_W'(1));
  assign overRange = sgn ? (magInt > limit) : (magInt >= limit);

  always_comb begin
    if (&expF)                           opClass = CLS_SPECIAL;
    else if (expF < EXP_W'(BIAS))        opClass = CLS_SMALL;
    else if (unb > EXP_W'(SIG_W - 1))    opClass = CLS_HUGE;
    else                                 opClass = CLS_FINITE;
  end

  logic [SIG_W-1:0] resNext;
  logic             invNext;
  logic             precNext;

  always_comb begin
    resNext  = '0;
    invNext  = 1'b0;
    precNext = 1'b0;
    case (opClass)
      CLS_SMALL: precNext = |sig;
      CLS_FINITE: begin
        if (overRange) begin
          invNext = 1'b1;
          resNext = indef;
        end else begin
          resNext  = sgn ? (~magInt + SIG_W'(1)) : magInt;
          precNext = lostBits;
        end
      end
      default: begin
        invNext = 1'b1;
        resNext = indef;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOut     <= '0;
      invalidOut <= 1'b0;
      precOut    <= 1'b0;
    end else if (strb.capture) begin
      resOut     <= resNext;
      invalidOut <= invNext;
      precOut    <= precNext;
    end
  end

endmodule

// File: rtl/xfp_trunc_cvt.sv
module xfp_trunc_cvt
  import xfp_trunc_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [EXP_W+SIG_W:0] operand,
  input  logic [1:0]           widthSel,
  output logic [SIG_W-1:0]     resOut,
  output logic                 invalidOut,
  output logic                 precOut,
  output logic                 popOut
);

  ctrl_strobe_t strb;

  xfp_trunc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .widthSel (widthSel),
    .strb     (strb),
    .popOut   (popOut)
  );

  xfp_trunc_dp #(
    .EXP_W (EXP_W),
    .SIG_W (SIG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .operand    (operand),
    .resOut     (resOut),
    .invalidOut (invalidOut),
    .precOut    (precOut)
  );

endmodule

// File: rtl/xfp_trunc_cvt_chk.sv
module xfp_trunc_cvt_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic [EXP_W+SIG_W:0] operand,
  input logic [1:0]           widthSel,
  input logic [SIG_W-1:0]     resOut,
  input logic                 invalidOut,
  input logic                 precOut,
  input logic                 popOut
);

  AST_POP_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> popOut); // R7

  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    popOut |-> $past(inValid)); // R7

  AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (&operand[EXP_W+SIG_W-1:SIG_W])) |=> invalidOut); // R2

  AST_INVALID_NO_PREC: assert property (@(posedge clk) disable iff (!rstN)
    invalidOut |-> !precOut); // R4

  AST_INDEF_16: assert property (@(posedge clk) disable iff (!rstN)
    (popOut && invalidOut && $past(widthSel) == 2'd0) |->
      resOut == {{(SIG_W-15){1'b1}}, 15'd0}); // R3

  AST_SIGNEXT_16: assert property (@(posedge clk) disable iff (!rstN)
    (popOut && $past(widthSel) == 2'd0) |->
      (resOut[SIG_W-1:15] == '0 || resOut[SIG_W-1:15] == '1)); // R6

  AST_SIGNEXT_32: assert property (@(posedge clk) disable iff (!rstN)
    (popOut && $past(widthSel) == 2'd1) |->
      (resOut[SIG_W-1:31] == '0 || resOut[SIG_W-1:31] == '1)); // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && $past(rstN)) |=> ($stable(resOut) && $stable(invalidOut) && $stable(precOut))); // R9

endmodule

bind xfp_trunc_cvt xfp_trunc_cvt_chk #(
  .EXP_W (EXP_W),
  .SIG_W (SIG_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .operand    (operand),
  .widthSel   (widthSel),
  .resOut     (resOut),
  .invalidOut (invalidOut),
  .precOut    (precOut),
  .popOut     (popOut)
);

// File: tb/xfp_trunc_cvt_bench.sv
module xfp_trunc_cvt_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BIAS = 16383;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [79:0] operand = '0;
  logic [1:0]  widthSel = '0;
  logic [63:0] resOut;
  logic        invalidOut;
  logic        precOut;
  logic        popOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfp_trunc_cvt u_xfp_trunc_cvt (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .operand    (operand),
    .widthSel   (widthSel),
    .resOut     (resOut),
    .invalidOut (invalidOut),
    .precOut    (precOut),
    .popOut     (popOut)
  );

  function automatic logic [79:0] mk(logic s, int e, logic [63:0] m);
    return {s, 15'(BIAS + e), m};
  endfunction

  // reference: {result, invalid, precision}
  function automatic logic [65:0] refModel(logic [79:0] op, logic [1:0] sel);
    int         w;
    int         e;
    logic [63:0] m;
    logic [63:0] ip;
    logic [64:0] lim;
    logic [63:0] ind;
    w = (sel == 2'd0) ? 16 : (sel == 2'd1) ? 32 : 64;
    lim = 65'd1 << (w - 1);
    ind = 64'hFFFF_FFFF_FFFF_FFFF << (w - 1);
    m = op[63:0];
    if (op[78:64] == 15'h7FFF) return {ind, 1'b1, 1'b0};
    e = int'(op[78:64]) - BIAS;
    if (e < 0) return {64'd0, 1'b0, (m != 0)};
    if (e > 63) return {ind, 1'b1, 1'b0};
    ip = m >> (63 - e);
    if (op[79] ? ({1'b0, ip} > lim) : ({1'b0, ip} >= lim)) return {ind, 1'b1, 1'b0};
    return {(op[79] ? 64'd0 - ip : ip), 1'b0, ((ip << (63 - e)) != m)};
  endfunction

  task automatic check(string tag, logic [65:0] act, logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual res=%h inv=%b prec=%b expected res=%h inv=%b prec=%b",
               tag, act[65:2], act[1], act[0], exp[65:2], exp[1], exp[0]);
    end
  endtask

  task automatic convert(string tag, logic [79:0] op, logic [1:0] sel);
    @(negedge clk);
    operand = op; widthSel = sel; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, {resOut, invalidOut, precOut}, refModel(op, sel));
    checks++;
    if (popOut !== 1'b1) begin
      fails++;
      $display("FAIL R7: popOut actual %b expected 1", popOut);
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [65:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 reset", {resOut, invalidOut, precOut}, 66'd0);
    checks++;
    if (popOut !== 1'b0) begin fails++; $display("FAIL R8: popOut actual %b expected 0", popOut); end
    rstN = 1'b1;

    // R1 truncation toward zero
    convert("R1 +2.75", mk(0, 1, 64'hB000_0000_0000_0000), 2'd2);
    convert("R1 -2.75", mk(1, 1, 64'hB000_0000_0000_0000), 2'd0);
    // R3 range edges at 16 bits
    convert("R3 +32767", mk(0, 14, 64'hFFFE_0000_0000_0000), 2'd0);
    convert("R3 +32768", mk(0, 15, 64'h8000_0000_0000_0000), 2'd0);
    convert("R3 -32768", mk(1, 15, 64'h8000_0000_0000_0000), 2'd0);
    convert("R3 R4 -32768.5", mk(1, 15, 64'h8000_8000_0000_0000), 2'd0);
    convert("R3 +2^31 w32", mk(0, 31, 64'h8000_0000_0000_0000), 2'd1);
    convert("R3 -2^63 w64", mk(1, 63, 64'h8000_0000_0000_0000), 2'd3);
    convert("R3 +2^63 w64", mk(0, 63, 64'h8000_0000_0000_0000), 2'd2);
    convert("R3 huge", mk(1, 200, 64'hC000_0000_0000_0000), 2'd1);
    // R2 specials
    convert("R2 +inf", {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 2'd1);
    convert("R2 NaN", {1'b1, 15'h7FFF, 64'hC000_0000_0000_0001}, 2'd0);
    // R5 small values
    convert("R5 zero", 80'd0, 2'd2);
    convert("R5 -0.5", mk(1, -1, 64'h8000_0000_0000_0000), 2'd0);
    convert("R5 denormal", {1'b0, 15'd0, 64'h0000_0000_0000_0001}, 2'd1);
    // R6 sign extension at 32 bits
    convert("R6 -5 w32", mk(1, 2, 64'hA000_0000_0000_0000), 2'd1);

    // R9 hold while idle
    held = {resOut, invalidOut, precOut};
    operand = {1'b1, 15'h7FFF, 64'd1}; widthSel = 2'd0;
    repeat (3) @(negedge clk);
    check("R9 hold", {resOut, invalidOut, precOut}, held);
    checks++;
    if (popOut !== 1'b0) begin fails++; $display("FAIL R7: idle popOut actual %b expected 0", popOut); end

    // random mix, R1 R3 R4 R5 R6
    for (int i = 0; i < 400; i++) begin
      logic [79:0] op;
      int e;
      logic [63:0] m;
      e = int'($urandom_range(70)) - 3;
      m = {$urandom(), $urandom()};
      if ($urandom_range(3) != 0) m[63] = 1'b1;
      if ($urandom_range(9) == 0) m = m >> $urandom_range(40);
      op = mk(1'($urandom()), e, m);
      if ($urandom_range(29) == 0) op[78:64] = 15'h7FFF;
      convert("R1 R3 R4 R6 random", op, 2'($urandom()));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule